// File: doc/BRIEF.md
# Posted Store Queue for a Load/Store Pipeline

This block sits between the memory stage of a processor pipeline and a single-port data bus. Stores from the memory stage are posted into a small first-in first-out queue. The pipeline moves on as soon as a slot is free, so it does not wait for the bus. This speeds up bursts of stores, such as stack saves at function entry or writes to uncached regions. The queue drains to the bus in arrival order with a valid/ack handshake and keeps at most one transaction in flight.

Loads are kept simple. A load in the memory stage stalls the pipeline until the queue is completely empty. The load then goes onto the bus, and the stall is released in the cycle its ack arrives. No address is ever compared against queued entries, and queued data is never returned to a load. Program order is kept by draining rather than by matching, so the block needs very little logic.

Top module: `sbuf_top`

## Requirements
- R1: After a synchronous active-high reset the queue is empty, `bus_valid` is 0, and `ms_stall` is 0 while `ms_valid` is 0.
- R2: A store (`ms_valid`=1, `ms_store`=1) is accepted without stall when the queue has a free slot. Its address, data and byte enables later appear unchanged on the bus with `bus_we`=1.
- R3: While a store request is on the bus and not acked, `bus_valid` and `bus_we` stay 1, and address, data and byte enables stay unchanged in the next cycle.
- R4: Queued stores are issued strictly oldest first, one at a time. An entry leaves the queue only in a cycle where `bus_ack` is 1, and the next entry is presented in the following cycle.
- R5: A store arriving when all DEPTH slots are occupied and no ack is received in that cycle gets `ms_stall`=1 and is not queued.
- R6: A store arriving when the queue is full, in the same cycle as an ack frees the oldest entry, is accepted with `ms_stall`=0.
- R7: A load (`ms_valid`=1, `ms_store`=0) sees `ms_stall`=1 while the queue holds any entry. During that time the bus carries only stores (`bus_we`=1).
- R8: When the queue is empty, a load drives `bus_valid`=1, `bus_we`=0, with the load's address and byte enables. `ms_stall` is 1 until the cycle in which `bus_ack` is 1; in that cycle it is 0 and `ms_rdata` equals `bus_rdata`.
- R9: With `ms_valid`=0 nothing is queued and `ms_stall` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| ms_valid | input | 1 | Memory-stage access present |
| ms_store | input | 1 | 1 = store, 0 = load |
| ms_addr | input | 32 | Access address |
| ms_wdata | input | 32 | Store data |
| ms_be | input | 4 | Byte enables |
| ms_stall | output | 1 | Hold the memory stage |
| ms_rdata | output | 32 | Load data, valid when a load completes |
| bus_valid | output | 1 | Bus request |
| bus_we | output | 1 | 1 = write, 0 = read |
| bus_addr | output | 32 | Bus address |
| bus_wdata | output | 32 | Bus write data |
| bus_be | output | 4 | Bus byte enables |
| bus_ack | input | 1 | Bus completes the current request |
| bus_rdata | input | 32 | Bus read data |

## Verification
The bench first sends a run of stores while the bus stays silent, which fills the queue and exercises the full-queue stall. It then opens the bus while stores keep coming, which tells the plain full stall apart from acceptance on the same cycle as a pop. After that come mixed load and store streams with acks on about half and then about a quarter of cycles. These separate a load blocked behind queued stores from a load issued to an empty queue. Idle memory-stage cycles are mixed in to show that nothing is queued without a request.

// File: rtl/sbuf_pkg.sv
package sbuf_pkg;

    parameter int ADDR_W = 32;
    parameter int DATA_W = 32;
    parameter int BE_W   = DATA_W / 8;

    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] data;
        logic [BE_W-1:0]   be;
    } sbuf_entry_t;

    typedef enum logic [1:0] {
        BUS_NONE  = 2'd0,
        BUS_WRITE = 2'd1,
        BUS_READ  = 2'd2
    } bus_kind_e;

    function automatic sbuf_entry_t make_entry(input logic [ADDR_W-1:0] a,
                                               input logic [DATA_W-1:0] d,
                                               input logic [BE_W-1:0]   b);
        sbuf_entry_t e;
        e.addr = a;
        e.data = d;
        e.be   = b;
        return e;
    endfunction

endpackage

// File: rtl/sbuf_fifo.sv
module sbuf_fifo
    import sbuf_pkg::*;
#(
    parameter int DEPTH = 4
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        push,
    input  sbuf_entry_t push_entry,
    input  logic        pop,
    output sbuf_entry_t head,
    output logic        empty,
    output logic        full
);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W = $clog2(DEPTH + 1);
    localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);
    localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);

    sbuf_entry_t       slot [DEPTH];
    logic [PTR_W-1:0]  wr_ptr, rd_ptr;
    logic [CNT_W-1:0]  count;

    function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
        return (p == LAST) ? '0 : p + 1'b1;
    endfunction

    for (genvar i = 0; i < DEPTH; i++) begin : g_slot
        always_ff @(posedge clk) begin
            if (push && (wr_ptr == PTR_W'(i)))
                slot[i] <= push_entry;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (push) wr_ptr <= bump(wr_ptr);
            if (pop)  rd_ptr <= bump(rd_ptr);
            case ({push, pop})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end

    assign head  = slot[rd_ptr];
    assign empty = (count == '0);
    assign full  = (count == FULL_CNT);

    // R4
    pop_guard_chk: assert property (@(posedge clk) disable iff (rst)
        pop |-> !empty);

    // R5
    no_overflow_chk: assert property (@(posedge clk) disable iff (rst)
        (push && full) |-> pop);

endmodule

// File: rtl/sbuf_arb.sv
module sbuf_arb
    import sbuf_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              q_empty,
    input  sbuf_entry_t       q_head,
    input  logic              ld_req,
    input  logic [ADDR_W-1:0] ld_addr,
    input  logic [BE_W-1:0]   ld_be,
    input  logic              bus_ack,
    output logic              bus_valid,
    output logic              bus_we,
    output logic [ADDR_W-1:0] bus_addr,
    output logic [DATA_W-1:0] bus_wdata,
    output logic [BE_W-1:0]   bus_be,
    output logic              q_pop,
    output logic              ld_done
);
    bus_kind_e kind;

    always_comb begin
        if (!q_empty)    kind = BUS_WRITE;
        else if (ld_req) kind = BUS_READ;
        else             kind = BUS_NONE;
    end

    always_comb begin
        bus_valid = (kind != BUS_NONE);
        bus_we    = (kind == BUS_WRITE);
        bus_wdata = q_head.data;
        if (kind == BUS_READ) begin
            bus_addr = ld_addr;
            bus_be   = ld_be;
        end else begin
            bus_addr = q_head.addr;
            bus_be   = q_head.be;
        end
    end

    assign q_pop   = (kind == BUS_WRITE) && bus_ack;
    assign ld_done = (kind == BUS_READ) && bus_ack;

    // R3
    store_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_valid && bus_we && !bus_ack) |=>
            (bus_valid && bus_we && $stable(bus_addr) && $stable(bus_wdata) && $stable(bus_be)));

endmodule

// File: rtl/sbuf_stall.sv
module sbuf_stall (
    input  logic clk,
    input  logic rst,
    input  logic ms_valid,
    input  logic ms_store,
    input  logic q_empty,
    input  logic q_full,
    input  logic q_pop,
    input  logic ld_done,
    output logic ms_stall,
    output logic q_push
);
    logic st_req, ld_req, st_blocked;

    assign st_req     = ms_valid && ms_store;
    assign ld_req     = ms_valid && !ms_store;
    assign st_blocked = q_full && !q_pop;

    assign ms_stall = (st_req && st_blocked) || (ld_req && !ld_done);
    assign q_push   = st_req && !st_blocked;

    // R7
    load_wait_chk: assert property (@(posedge clk) disable iff (rst)
        (ms_valid && !ms_store && !q_empty) |-> ms_stall);

    // R5
    full_stall_chk: assert property (@(posedge clk) disable iff (rst)
        (ms_valid && ms_store && q_full && !q_pop) |-> (ms_stall && !q_push));

endmodule

// File: rtl/sbuf_top.sv
module sbuf_top
    import sbuf_pkg::*;
#(
    parameter int DEPTH = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ms_valid,
    input  logic              ms_store,
    input  logic [ADDR_W-1:0] ms_addr,
    input  logic [DATA_W-1:0] ms_wdata,
    input  logic [BE_W-1:0]   ms_be,
    output logic              ms_stall,
    output logic [DATA_W-1:0] ms_rdata,
    output logic              bus_valid,
    output logic              bus_we,
    output logic [ADDR_W-1:0] bus_addr,
    output logic [DATA_W-1:0] bus_wdata,
    output logic [BE_W-1:0]   bus_be,
    input  logic              bus_ack,
    input  logic [DATA_W-1:0] bus_rdata
);
    sbuf_entry_t head;
    logic        q_empty, q_full, q_push, q_pop, ld_done;

    sbuf_fifo #(.DEPTH(DEPTH)) u_fifo (
        .clk        (clk),
        .rst        (rst),
        .push       (q_push),
        .push_entry (make_entry(ms_addr, ms_wdata, ms_be)),
        .pop        (q_pop),
        .head       (head),
        .empty      (q_empty),
        .full       (q_full)
    );

    sbuf_arb u_arb (
        .clk       (clk),
        .rst       (rst),
        .q_empty   (q_empty),
        .q_head    (head),
        .ld_req    (ms_valid && !ms_store),
        .ld_addr   (ms_addr),
        .ld_be     (ms_be),
        .bus_ack   (bus_ack),
        .bus_valid (bus_valid),
        .bus_we    (bus_we),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_be    (bus_be),
        .q_pop     (q_pop),
        .ld_done   (ld_done)
    );

    sbuf_stall u_stall (
        .clk      (clk),
        .rst      (rst),
        .ms_valid (ms_valid),
        .ms_store (ms_store),
        .q_empty  (q_empty),
        .q_full   (q_full),
        .q_pop    (q_pop),
        .ld_done  (ld_done),
        .ms_stall (ms_stall),
        .q_push   (q_push)
    );

    assign ms_rdata = bus_rdata;

    // R8
    read_order_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_valid && !bus_we) |-> (ms_valid && !ms_store));

endmodule

// File: tb/sbuf_top_bench.sv
`timescale 1ns/1ps
module sbuf_top_bench;
    localparam int DEPTH = 4;
    localparam int NCYC  = 3000;

    logic        clk = 1'b0;
    logic        rst;
    logic        ms_valid, ms_store;
    logic [31:0] ms_addr, ms_wdata;
    logic [3:0]  ms_be;
    logic        ms_stall;
    logic [31:0] ms_rdata;
    logic        bus_valid, bus_we;
    logic [31:0] bus_addr, bus_wdata;
    logic [3:0]  bus_be;
    logic        bus_ack;
    logic [31:0] bus_rdata;

    always #2.5 clk = ~clk;

    sbuf_top #(.DEPTH(DEPTH)) u_sbuf_top (
        .clk(clk), .rst(rst),
        .ms_valid(ms_valid), .ms_store(ms_store), .ms_addr(ms_addr),
        .ms_wdata(ms_wdata), .ms_be(ms_be), .ms_stall(ms_stall), .ms_rdata(ms_rdata),
        .bus_valid(bus_valid), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_be(bus_be), .bus_ack(bus_ack), .bus_rdata(bus_rdata)
    );

    typedef struct { logic [31:0] a; logic [31:0] d; logic [3:0] b; } ent_t;
    ent_t q[$];

    int nvec = 0;
    int nbad = 0;
    bit done = 0;
    logic [31:0] seed = 32'h1234_5678;

    function automatic logic [31:0] rnd();
        seed = seed * 32'd1103515245 + 32'd12345;
        return seed;
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        nvec++;
        if (act !== exp) begin
            nbad++;
            $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
        end
    endtask

    initial begin
        #200000;
        if (!done) begin
            nbad++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
            $finish;
        end
    end

    initial begin
        bit hold;
        bit e_empty, e_pop, e_ld, e_stall;
        logic [31:0] r;
        rst = 1'b1; ms_valid = 0; ms_store = 0; ms_addr = 0; ms_wdata = 0; ms_be = 0;
        bus_ack = 0; bus_rdata = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1: reset state
        chk("R1 bus_valid", 32'(bus_valid), 0);
        chk("R1 ms_stall", 32'(ms_stall), 0);
        rst = 1'b0;
        hold = 0;
        for (int cyc = 0; cyc < NCYC; cyc++) begin
            if (cyc > 0) @(negedge clk);
            r = rnd();
            if (!hold) begin
                if (cyc < 40) begin
                    ms_valid = 1; ms_store = 1;
                end else begin
                    ms_valid = (r[3:2] != 2'b00);
                    ms_store = (r[6:4] > 3'd1);
                end
                ms_addr = rnd(); ms_wdata = rnd(); ms_be = r[11:8];
            end
            if (cyc < 20)       bus_ack = 0;
            else if (cyc < 40)  bus_ack = 1;
            else if (cyc < 800) bus_ack = r[15];
            else                bus_ack = (r[17:16] == 2'b00);
            bus_rdata = rnd();
            #1;
            e_empty = (q.size() == 0);
            e_pop   = !e_empty && bus_ack;
            e_ld    = e_empty && ms_valid && !ms_store && bus_ack;
            if (!ms_valid) e_stall = 0;
            else if (ms_store) e_stall = (q.size() == DEPTH) && !e_pop;
            else e_stall = !e_ld;
            // stall checks
            if (!ms_valid) chk("R9 stall", 32'(ms_stall), 0);
            else if (ms_store) begin
                if (q.size() < DEPTH) chk("R2 stall", 32'(ms_stall), 32'(e_stall));
                else if (e_pop)       chk("R6 stall", 32'(ms_stall), 32'(e_stall));
                else                  chk("R5 stall", 32'(ms_stall), 32'(e_stall));
            end else begin
                if (!e_empty) chk("R7 stall", 32'(ms_stall), 32'(e_stall));
                else          chk("R8 stall", 32'(ms_stall), 32'(e_stall));
            end
            // bus checks
            if (!e_empty) begin
                chk("R4 bus_valid", 32'(bus_valid), 1);
                if (ms_valid && !ms_store) chk("R7 bus_we", 32'(bus_we), 1);
                else                       chk("R3 bus_we", 32'(bus_we), 1);
                chk("R2 bus_addr", bus_addr, q[0].a);
                chk("R2 bus_wdata", bus_wdata, q[0].d);
                chk("R2 bus_be", 32'(bus_be), 32'(q[0].b));
            end else if (ms_valid && !ms_store) begin
                chk("R8 bus_valid", 32'(bus_valid), 1);
                chk("R8 bus_we", 32'(bus_we), 0);
                chk("R8 bus_addr", bus_addr, ms_addr);
                chk("R8 bus_be", 32'(bus_be), 32'(ms_be));
                if (e_ld) chk("R8 ms_rdata", ms_rdata, bus_rdata);
            end else begin
                chk("R9 bus_valid", 32'(bus_valid), 0);
            end
            @(posedge clk);
            if (e_pop) void'(q.pop_front());
            if (ms_valid && ms_store && !e_stall)
                q.push_back('{a: ms_addr, d: ms_wdata, b: ms_be});
            hold = ms_valid && e_stall;
        end
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
        $finish;
    end
endmodule